// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Clock Divider

This block divides a fast input clock down to a slow comparison pulse for a frequency synthesizer loop. It runs entirely in the input clock domain. In normal mode a prescaler stage divides by ten or eleven. A main counter counts prescaler cycles, and a swallow counter decides how many of those cycles use the long (eleven) modulus. The overall ratio is therefore 10·(M+1)+A. When the bypass control is set, the prescaler and the swallow counter stand idle, and the main counter divides the input clock by M+1 directly.

Each completed division period produces one output pulse, one input-clock cycle wide. The M, A and bypass settings are sampled at period boundaries only, so a change never produces a truncated or stretched period. A swallow value larger than M+1 is limited to M+1.

Top module: `pswallow_divider`

## Requirements
- R1: With bypass_i = 0 and A ≤ M+1, the distance between consecutive fp_o pulses is 10·(M+1)+A input clock cycles (M is the 9-bit main_div_i, A is the 4-bit swallow_i).
- R2: With bypass_i = 1, the pulse distance is M+1 cycles and swallow_i has no effect on it.
- R3: fp_o is high for exactly one cycle per period whenever the period is two or more cycles.
- R4: rst is synchronous and active high. While it is asserted fp_o is 0. After release, the first pulse appears on the N-th rising clock edge, where N is the current division ratio.
- R5: Values on main_div_i, swallow_i and bypass_i are captured only when a period completes, or during reset. A change made within a period leaves that period's length unchanged, and it sets the length of the following period.
- R6: If A > M+1 in normal mode, the effective swallow count is M+1, giving a period of 11·(M+1).
- R7: At the minimum M = 1 the main counter divides by 2: 20+A cycles in normal mode and 2 cycles in bypass mode.
- R8: Asserting rst in the middle of a period discards the partial count. The next pulse follows release after a full N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (VCO-side) clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| main_div_i | input | 9 | Main counter setting M (valid 1..511) |
| swallow_i | input | 4 | Swallow count A (long-modulus prescaler cycles per period) |
| bypass_i | input | 1 | 1 = skip prescaler and swallow counter, divide by M+1 |
| fp_o | output | 1 | One-cycle pulse per completed division period |

## Verification
fp_o is a registered output. It rises one edge after the final cycle of a period, so a pulse appears on the N-th clock edge after reset release and then every N edges. The bench drives and samples on falling edges. It counts the falling edges from reset release, or from the previous pulse, until fp_o is seen high, and compares that count with a ratio it computes from the settings. For setting changes, the bench drives the new values right after a pulse has been seen, which is after the capture edge. The interval that follows must still carry the old ratio, and the interval after that the new one.

// File: rtl/pswallow_pkg.sv
`timescale 1ns/1ps
package pswallow_pkg;

  // Swallow count actually used: never more than the number of prescaler
  // cycles in one period (M+1).
  function automatic int unsigned clamp_swallow(input int unsigned m,
                                                input int unsigned a);
    return (a > m + 1) ? (m + 1) : a;
  endfunction

  // Input cycles in one complete period for a given effective setting.
  function automatic int unsigned period_len(input bit          byp,
                                             input int unsigned m,
                                             input int unsigned a_eff,
                                             input int unsigned base);
    return byp ? (m + 1) : (base * (m + 1) + a_eff);
  endfunction

endpackage

// File: rtl/psw_cfg_hold.sv
`timescale 1ns/1ps
module psw_cfg_hold #(
  parameter int M_W = 9,
  parameter int A_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic [M_W-1:0] m_i,
  input  logic [A_W-1:0] a_i,
  input  logic           bypass_i,
  output logic [M_W-1:0] m_o,
  output logic [A_W-1:0] a_o,
  output logic           bypass_o
);
  import pswallow_pkg::*;

  logic [A_W-1:0] a_lim;
  assign a_lim = A_W'(clamp_swallow(32'(m_i), 32'(a_i)));

  // Settings are captured during reset and at each period boundary only.
  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      m_o      <= m_i;
      a_o      <= a_lim;
      bypass_o <= bypass_i;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(m_o) && $stable(a_o) && $stable(bypass_o))); // R5
  AST_SWALLOW_CLAMPED: assert property (@(posedge clk) disable iff (rst)
    (32'(a_o) <= 32'(m_o) + 1)); // R6

endmodule

// File: rtl/psw_prescaler.sv
`timescale 1ns/1ps
module psw_prescaler #(
  parameter int PRE_BASE = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic bypass_i,
  input  logic long_i,
  output logic tick_o
);
  localparam int PC_W = $clog2(PRE_BASE + 1);

  logic [PC_W-1:0] pcnt;
  logic [PC_W-1:0] last_val;
  logic            wrap;

  assign last_val = long_i ? PC_W'(PRE_BASE) : PC_W'(PRE_BASE - 1);
  assign wrap     = (pcnt == last_val);
  // In bypass every input cycle advances the main counter.
  assign tick_o   = bypass_i | wrap;

  always_ff @(posedge clk) begin
    if (rst || bypass_i || wrap) pcnt <= '0;
    else                         pcnt <= pcnt + 1'b1;
  end

  // The modulus may only drop back to the short value on a boundary.
  AST_PRE_SHORT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (!bypass_i && !long_i) |-> (32'(pcnt) < PRE_BASE)); // R1
  AST_PRE_IDLE_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (bypass_i && $past(bypass_i)) |-> (pcnt == '0)); // R2

endmodule

// File: rtl/psw_chain.sv
`timescale 1ns/1ps
module psw_chain #(
  parameter int M_W = 9,
  parameter int A_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick_i,
  input  logic           bypass_i,
  input  logic [M_W-1:0] m_i,
  input  logic [A_W-1:0] a_i,
  output logic           long_o,
  output logic           end_o
);
  logic [M_W-1:0] mcnt;
  logic [A_W-1:0] scnt;

  assign long_o = !bypass_i && (scnt < a_i);
  assign end_o  = tick_i && (mcnt == m_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      mcnt <= '0;
      scnt <= '0;
    end else if (tick_i) begin
      if (end_o) begin
        mcnt <= '0;
        scnt <= '0;
      end else begin
        mcnt <= mcnt + 1'b1;
        if (long_o) scnt <= scnt + 1'b1;
      end
    end
  end

  AST_MAIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    mcnt <= m_i); // R1
  AST_SWALLOW_BOUND: assert property (@(posedge clk) disable iff (rst)
    scnt <= a_i); // R6
  AST_SWALLOW_DONE: assert property (@(posedge clk) disable iff (rst)
    (end_o && !bypass_i) |->
      ((A_W+1)'(scnt) + (A_W+1)'(long_o) == (A_W+1)'(a_i))); // R1

endmodule

// File: rtl/pswallow_divider.sv
`timescale 1ns/1ps
module pswallow_divider #(
  parameter int M_W      = 9,
  parameter int A_W      = 4,
  parameter int PRE_BASE = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [M_W-1:0] main_div_i,
  input  logic [A_W-1:0] swallow_i,
  input  logic           bypass_i,
  output logic           fp_o
);
  import pswallow_pkg::*;

  localparam int MAX_RATIO = PRE_BASE * (2 ** M_W) + (2 ** A_W);
  localparam int CNT_W     = $clog2(MAX_RATIO + 1);

  logic [M_W-1:0] m_q;
  logic [A_W-1:0] a_q;
  logic           byp_q;
  logic           pre_tick;
  logic           long_phase;
  logic           period_end;

  psw_cfg_hold #(.M_W(M_W), .A_W(A_W)) u_cfg (
    .clk(clk), .rst(rst), .load_i(period_end),
    .m_i(main_div_i), .a_i(swallow_i), .bypass_i(bypass_i),
    .m_o(m_q), .a_o(a_q), .bypass_o(byp_q)
  );

  psw_prescaler #(.PRE_BASE(PRE_BASE)) u_pre (
    .clk(clk), .rst(rst), .bypass_i(byp_q), .long_i(long_phase),
    .tick_o(pre_tick)
  );

  psw_chain #(.M_W(M_W), .A_W(A_W)) u_chain (
    .clk(clk), .rst(rst), .tick_i(pre_tick), .bypass_i(byp_q),
    .m_i(m_q), .a_i(a_q), .long_o(long_phase), .end_o(period_end)
  );

  always_ff @(posedge clk) begin
    if (rst) fp_o <= 1'b0;
    else     fp_o <= period_end;
  end

  // Independent period meter used only by the checks below.
  logic [CNT_W-1:0] per_cnt;
  always_ff @(posedge clk) begin
    if (rst || period_end) per_cnt <= '0;
    else                   per_cnt <= per_cnt + 1'b1;
  end

  AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (rst)
    period_end |-> (32'(per_cnt) + 1 ==
                    period_len(byp_q, 32'(m_q), 32'(a_q), PRE_BASE))); // R1
  AST_FP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (fp_o && !(byp_q && m_q == '0)) |=> !fp_o); // R3
  AST_FP_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !fp_o); // R4

endmodule

// File: tb/pswallow_divider_tb.sv
`timescale 1ns/1ps
module pswallow_divider_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] m_in = 9'd5;
  logic [3:0] a_in = 4'd0;
  logic       byp_in = 1'b0;
  logic       fp;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  pswallow_divider u_dut (
    .clk(clk), .rst(rst), .main_div_i(m_in), .swallow_i(a_in),
    .bypass_i(byp_in), .fp_o(fp)
  );

  function automatic int exp_len(input bit b, input int m, input int a);
    int lim;
    if (b) return m + 1;
    lim = (a > m + 1) ? m + 1 : a;
    return 10 * (m + 1) + lim;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Counts falling edges until fp is seen high; hi_next tells whether fp
  // was still high on the first falling edge counted.
  task automatic pulse_gap(output int n, output bit hi_next);
    n = 0;
    hi_next = 1'b0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) hi_next = fp;
    end while (fp !== 1'b1 && n < 6000);
  endtask

  task automatic start(input bit b, input int m, input int a);
    @(negedge clk);
    byp_in = b; m_in = 9'(m); a_in = 4'(a);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(fp === 1'b0, "R4 fp low in reset", int'(fp), 0);
    end
    rst = 1'b0;
  endtask

  task automatic run_cfg(input bit b, input int m, input int a, input string tag);
    int n; bit h; int e;
    e = exp_len(b, m, a);
    start(b, m, a);
    pulse_gap(n, h);
    check(n == e, {tag, " first pulse (R4)"}, n, e);
    pulse_gap(n, h);
    check(n == e, {tag, " period"}, n, e);
    if (e >= 2) check(h == 1'b0, "R3 pulse one cycle wide", int'(h), 0);
  endtask

  task automatic t_normal();
    run_cfg(0, 5, 3, "R1 M5 A3");
    run_cfg(0, 20, 0, "R1 M20 A0");
    run_cfg(0, 9, 10, "R1 A=M+1");
    run_cfg(0, 511, 15, "R1 max M");
  endtask

  task automatic t_bypass();
    int n; bit h;
    run_cfg(1, 37, 9, "R2 bypass M37");
    a_in = 4'd15;
    pulse_gap(n, h);
    check(n == 38, "R2 swallow ignored in bypass", n, 38);
    pulse_gap(n, h);
    check(n == 38, "R2 swallow ignored in bypass", n, 38);
  endtask

  task automatic t_clamp();
    run_cfg(0, 3, 15, "R6 clamp M3 A15");
    run_cfg(0, 1, 15, "R6 clamp M1 A15");
  endtask

  task automatic t_min();
    run_cfg(0, 1, 0, "R7 M1 A0");
    run_cfg(0, 1, 2, "R7 M1 A2");
    run_cfg(1, 1, 0, "R7 bypass M1");
  endtask

  task automatic t_change();
    int n; bit h;
    start(0, 4, 2);
    pulse_gap(n, h);
    check(n == 52, "R5 initial period", n, 52);
    m_in = 9'd7; a_in = 4'd1;
    pulse_gap(n, h);
    check(n == 52, "R5 old ratio kept", n, 52);
    pulse_gap(n, h);
    check(n == 81, "R5 new ratio applied", n, 81);
    byp_in = 1'b1;
    pulse_gap(n, h);
    check(n == 81, "R5 bypass waits for boundary", n, 81);
    pulse_gap(n, h);
    check(n == 8, "R5 bypass applied", n, 8);
  endtask

  task automatic t_reset_mid();
    int n; bit h; bit seen;
    start(0, 6, 4);
    pulse_gap(n, h);
    check(n == 74, "R8 initial period", n, 74);
    seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (fp) seen = 1'b1;
    end
    check(seen == 1'b0, "R8 no pulse mid period", int'(seen), 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(fp === 1'b0, "R8 fp low during reset", int'(fp), 0);
    rst = 1'b0;
    pulse_gap(n, h);
    check(n == 74, "R8 full period after reset", n, 74);
  endtask

  initial begin
    wait (cyc >= 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog all-R actual=%0d expected<150000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_normal();
    t_bypass();
    t_clamp();
    t_min();
    t_change();
    t_reset_mid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule